// File: doc/BRIEF.md
# Page History Bit Update Controller

This controller sits between the address translation path and the memory bus. For every access it decides whether the referenced and changed history bits of the page table entry (PTE) must be brought up to date. When they must, it updates them in physical memory. The caller presents one access at a time, together with:

- its kind and translation path,
- the segment's direct-store flag and the two translation enable bits,
- the TLB lookup result with the cached R and C bits,
- the physical address of the PTE, supplied by the table walker.

An update is always done the same way, whatever address translation is in force. The controller issues a single-beat read of the PTE byte that holds R and C. It merges in the bits the access needs. It then writes that one byte back, but only if its value changes. Accesses that need no update retire with no bus traffic. A cache touch that misses translation is reported as a no-op. An impossible TLB state is reported as illegal.

While a request is in flight the controller raises a busy output and ignores new requests. When a store has driven an update, it pulses a signal telling the TLB to mark its cached C bit. Later stores to the same page then retire locally.

Top module: `pghist_ctrl`

## Requirements
- R1: An access whose path is block translation (req_path 1) or untranslated (req_path 2 or 3), or that targets a direct-store segment, retires with done_o and causes no bus read or write.
- R2: An access on the page table path (req_path 0) while both translation enable inputs are 0 retires with no bus read or write.
- R3: A tracked TLB hit with cached R=1 causes no bus traffic when it is a load or either touch kind (req_kind 0, 2, 3), or when the cached C is 1.
- R4: A tracked TLB hit by a store (req_kind 1) with cached R=1 and C=0 reads the PTE byte and writes it back with both R and C set.
- R5: A tracked TLB hit with cached R=0 retires with illegal_o high in the done_o cycle and no bus traffic.
- R6: A tracked TLB miss by a touch (req_kind 2 or 3) retires with noop_o high in the done_o cycle and no bus traffic.
- R7: A tracked TLB miss by a load or store issues one single-cycle bus_rd_req to req_pte_addr + 6. The history byte has R at bit 1 and C at bit 0. A bus_wr_req to the same address follows only if the byte changes. Its data is the read byte ORed with 0x02, plus 0x01 for a store, and all other bits stay as read.
- R8: tlb_set_c_o pulses together with done_o exactly for stores that went through the PTE read (R4 and store misses).
- R9: busy_o is high from the cycle after a request is accepted through the single done_o cycle. Requests presented while busy_o is high are ignored. done_o is a one-cycle pulse followed by idle.
- R10: During and right after reset, busy_o, done_o, bus_rd_req and bus_wr_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, accepted when busy_o is low |
| req_kind | input | 2 | 0 load, 1 store, 2 touch, 3 touch-for-store |
| req_path | input | 2 | 0 page table, 1 block translation, 2/3 untranslated |
| req_direct_store | input | 1 | Segment is direct-store |
| req_itrans_en | input | 1 | Instruction translation enabled |
| req_dtrans_en | input | 1 | Data translation enabled |
| req_tlb_hit | input | 1 | TLB lookup hit |
| req_tlb_r | input | 1 | Cached R bit of the hit entry |
| req_tlb_c | input | 1 | Cached C bit of the hit entry |
| req_pte_addr | input | PA_W | Physical address of the PTE |
| busy_o | output | 1 | Request in flight |
| bus_rd_req | output | 1 | Single-beat read strobe |
| bus_rd_addr | output | PA_W | Byte address of the read |
| bus_rd_ack | input | 1 | Read data valid |
| bus_rd_data | input | BYTE_W | Returned history byte |
| bus_wr_req | output | 1 | Byte write strobe |
| bus_wr_addr | output | PA_W | Byte address of the write |
| bus_wr_data | output | BYTE_W | Merged history byte |
| bus_wr_ack | input | 1 | Write completed |
| done_o | output | 1 | Request retired (one cycle) |
| noop_o | output | 1 | Retired as a touch no-op |
| illegal_o | output | 1 | Retired with an impossible cached R,C |
| tlb_set_c_o | output | 1 | Set C in the cached TLB entry |

## Verification
The bench targets four corner cases.

- **Store hitting a clean TLB entry.** A design that treated every hit as already recorded would return without a read, so the PTE's C bit would never be set.
- **Touch miss.** A touch miss must retire silently. Treating touches as loads would start a read and set R.
- **Returned byte already holds the needed bits.** The write must be skipped here. Other bits in the byte carry random values, so a merge that clears or overwrites them gives a wrong write value.
- **Requests during busy.** New requests are held on the inputs for the whole update. A design that accepts them would start a second read after retiring.

// File: rtl/pghist_pkg.sv
package pghist_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD     = 2'd0,
    ACC_STORE    = 2'd1,
    ACC_TOUCH    = 2'd2,
    ACC_TOUCH_ST = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    XP_PAGE  = 2'd0,
    XP_BLOCK = 2'd1,
    XP_NONE  = 2'd2,
    XP_RSVD  = 2'd3
  } xlate_path_e;

  typedef enum logic [1:0] {
    ACT_SKIP    = 2'd0,
    ACT_NOOP    = 2'd1,
    ACT_UPDATE  = 2'd2,
    ACT_ILLEGAL = 2'd3
  } hist_act_e;

  typedef enum logic [2:0] {
    S_IDLE       = 3'd0,
    S_READ_PTE   = 3'd1,
    S_WAIT_READ  = 3'd2,
    S_WRITE_BYTE = 3'd3,
    S_WAIT_WRITE = 3'd4,
    S_DONE       = 3'd5
  } seq_state_e;

endpackage

// File: rtl/pghist_classify.sv
module pghist_classify
  import pghist_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int R_BIT  = 1,
  parameter int C_BIT  = 0
) (
  input  logic [1:0]        kind,
  input  logic [1:0]        path,
  input  logic              direct_store,
  input  logic              itrans_en,
  input  logic              dtrans_en,
  input  logic              tlb_hit,
  input  logic              tlb_r,
  input  logic              tlb_c,
  output hist_act_e         act,
  output logic [BYTE_W-1:0] set_mask
);

  acc_kind_e   k;
  xlate_path_e p;
  logic        is_store;
  logic        is_touch;
  logic        tracked;

  always_comb begin
    k        = acc_kind_e'(kind);
    p        = xlate_path_e'(path);
    is_store = (k == ACC_STORE);
    is_touch = (k == ACC_TOUCH) || (k == ACC_TOUCH_ST);
    // only page-table translated, non direct-store, translation-on accesses
    tracked  = (p == XP_PAGE) && !direct_store && (itrans_en || dtrans_en);

    set_mask        = '0;
    set_mask[R_BIT] = 1'b1;
    if (is_store) begin
      set_mask[C_BIT] = 1'b1;
    end

    act = ACT_SKIP;
    if (tracked) begin
      if (!tlb_hit) begin
        act = is_touch ? ACT_NOOP : ACT_UPDATE;
      end else if (!tlb_r) begin
        act = ACT_ILLEGAL;
      end else if (is_store && !tlb_c) begin
        act = ACT_UPDATE;
      end
    end
  end

endmodule

// File: rtl/pghist_merge.sv
module pghist_merge #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] old_byte,
  input  logic [BYTE_W-1:0] set_mask,
  output logic [BYTE_W-1:0] new_byte,
  output logic              changed
);

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign new_byte[i] = old_byte[i] | set_mask[i];
  end

  assign changed = |(set_mask & ~old_byte);

endmodule

// File: rtl/pghist_seq.sv
module pghist_seq
  import pghist_pkg::*;
#(
  parameter int PA_W          = 32,
  parameter int BYTE_W        = 8,
  parameter int C_BIT         = 0,
  parameter int HIST_BYTE_OFS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  hist_act_e         act,
  input  logic [BYTE_W-1:0] set_mask,
  input  logic [PA_W-1:0]   pte_addr,
  input  logic              rd_ack,
  input  logic              wr_ack,
  input  logic [BYTE_W-1:0] merged_byte,
  input  logic              merged_changed,
  output logic [BYTE_W-1:0] mask_q,
  output logic [PA_W-1:0]   addr_q,
  output logic [BYTE_W-1:0] wbyte_q,
  output logic              busy,
  output logic              rd_req,
  output logic              wr_req,
  output logic              done,
  output logic              noop,
  output logic              illegal,
  output logic              tlb_set_c
);

  localparam logic [PA_W-1:0] OFS = PA_W'(HIST_BYTE_OFS);

  seq_state_e state_q, state_d;
  logic       cap_en;
  logic       rdcap_en;
  logic       noop_q;
  logic       illegal_q;
  logic       setc_q;

  always_comb begin
    state_d  = state_q;
    cap_en   = 1'b0;
    rdcap_en = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          state_d = (act == ACT_UPDATE) ? S_READ_PTE : S_DONE;
        end
      end
      S_READ_PTE:   state_d = S_WAIT_READ;
      S_WAIT_READ: begin
        if (rd_ack) begin
          rdcap_en = 1'b1;
          state_d  = merged_changed ? S_WRITE_BYTE : S_DONE;
        end
      end
      S_WRITE_BYTE: state_d = S_WAIT_WRITE;
      S_WAIT_WRITE: begin
        if (wr_ack) begin
          state_d = S_DONE;
        end
      end
      S_DONE:       state_d = S_IDLE;
      default:      state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      noop_q    <= 1'b0;
      illegal_q <= 1'b0;
      setc_q    <= 1'b0;
    end else if (cap_en) begin
      noop_q    <= (act == ACT_NOOP);
      illegal_q <= (act == ACT_ILLEGAL);
      setc_q    <= (act == ACT_UPDATE) && set_mask[C_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q <= pte_addr + OFS;
      mask_q <= set_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rdcap_en) begin
      wbyte_q <= merged_byte;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign rd_req    = (state_q == S_READ_PTE);
  assign wr_req    = (state_q == S_WRITE_BYTE);
  assign done      = (state_q == S_DONE);
  assign noop      = done && noop_q;
  assign illegal   = done && illegal_q;
  assign tlb_set_c = done && setc_q;

endmodule

// File: rtl/pghist_ctrl.sv
module pghist_ctrl
  import pghist_pkg::*;
#(
  parameter int PA_W          = 32,
  parameter int BYTE_W        = 8,
  parameter int R_BIT         = 1,
  parameter int C_BIT         = 0,
  parameter int HIST_BYTE_OFS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_path,
  input  logic              req_direct_store,
  input  logic              req_itrans_en,
  input  logic              req_dtrans_en,
  input  logic              req_tlb_hit,
  input  logic              req_tlb_r,
  input  logic              req_tlb_c,
  input  logic [PA_W-1:0]   req_pte_addr,
  output logic              busy_o,
  output logic              bus_rd_req,
  output logic [PA_W-1:0]   bus_rd_addr,
  input  logic              bus_rd_ack,
  input  logic [BYTE_W-1:0] bus_rd_data,
  output logic              bus_wr_req,
  output logic [PA_W-1:0]   bus_wr_addr,
  output logic [BYTE_W-1:0] bus_wr_data,
  input  logic              bus_wr_ack,
  output logic              done_o,
  output logic              noop_o,
  output logic              illegal_o,
  output logic              tlb_set_c_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  hist_act_e         act;
  logic [BYTE_W-1:0] set_mask;
  logic [BYTE_W-1:0] mask_q;
  logic [BYTE_W-1:0] merged_byte;
  logic              merged_changed;
  logic [PA_W-1:0]   addr_q;
  logic [BYTE_W-1:0] wbyte_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  pghist_classify #(
    .BYTE_W (BYTE_W),
    .R_BIT  (R_BIT),
    .C_BIT  (C_BIT)
  ) u_classify (
    .kind         (req_kind),
    .path         (req_path),
    .direct_store (req_direct_store),
    .itrans_en    (req_itrans_en),
    .dtrans_en    (req_dtrans_en),
    .tlb_hit      (req_tlb_hit),
    .tlb_r        (req_tlb_r),
    .tlb_c        (req_tlb_c),
    .act          (act),
    .set_mask     (set_mask)
  );

  pghist_merge #(
    .BYTE_W (BYTE_W)
  ) u_merge (
    .old_byte (bus_rd_data),
    .set_mask (mask_q),
    .new_byte (merged_byte),
    .changed  (merged_changed)
  );

  pghist_seq #(
    .PA_W          (PA_W),
    .BYTE_W        (BYTE_W),
    .C_BIT         (C_BIT),
    .HIST_BYTE_OFS (HIST_BYTE_OFS)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .req_valid      (req_valid),
    .act            (act),
    .set_mask       (set_mask),
    .pte_addr       (req_pte_addr),
    .rd_ack         (bus_rd_ack),
    .wr_ack         (bus_wr_ack),
    .merged_byte    (merged_byte),
    .merged_changed (merged_changed),
    .mask_q         (mask_q),
    .addr_q         (addr_q),
    .wbyte_q        (wbyte_q),
    .busy           (busy_o),
    .rd_req         (bus_rd_req),
    .wr_req         (bus_wr_req),
    .done           (done_o),
    .noop           (noop_o),
    .illegal        (illegal_o),
    .tlb_set_c      (tlb_set_c_o)
  );

  assign bus_rd_addr = addr_q;
  assign bus_wr_addr = addr_q;
  assign bus_wr_data = wbyte_q;

endmodule

// File: rtl/pghist_ctrl_chk.sv
module pghist_ctrl_chk #(
  parameter int PA_W   = 32,
  parameter int BYTE_W = 8,
  parameter int R_BIT  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              noop_o,
  input logic              illegal_o,
  input logic              tlb_set_c_o,
  input logic              bus_rd_req,
  input logic              bus_rd_ack,
  input logic [PA_W-1:0]   bus_rd_addr,
  input logic              bus_wr_req,
  input logic [PA_W-1:0]   bus_wr_addr,
  input logic [BYTE_W-1:0] bus_wr_data
);

  logic            rd_seen_q;
  logic [PA_W-1:0] rd_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_seen_q <= 1'b0;
    end else if (done_o) begin
      rd_seen_q <= 1'b0;
    end else if (bus_rd_ack) begin
      rd_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
    end else if (bus_rd_req) begin
      rd_addr_q <= bus_rd_addr;
    end
  end

  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_req |=> !bus_rd_req);

  assert_wr_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_req |=> !bus_wr_req);

  assert_wr_after_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_req |-> (rd_seen_q && (bus_wr_addr == rd_addr_q)));

  assert_wr_sets_r_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_req |-> bus_wr_data[R_BIT]);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(bus_rd_req || bus_wr_req || done_o));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  assert_tlbc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_set_c_o |-> (done_o && rd_seen_q));

  assert_illegal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (done_o && !rd_seen_q));

  assert_noop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    noop_o |-> (done_o && !rd_seen_q && !illegal_o));

endmodule

bind pghist_ctrl pghist_ctrl_chk #(
  .PA_W   (PA_W),
  .BYTE_W (BYTE_W),
  .R_BIT  (R_BIT)
) u_pghist_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .noop_o      (noop_o),
  .illegal_o   (illegal_o),
  .tlb_set_c_o (tlb_set_c_o),
  .bus_rd_req  (bus_rd_req),
  .bus_rd_ack  (bus_rd_ack),
  .bus_rd_addr (bus_rd_addr),
  .bus_wr_req  (bus_wr_req),
  .bus_wr_addr (bus_wr_addr),
  .bus_wr_data (bus_wr_data)
);

// File: tb/test_pghist_ctrl.sv
`timescale 1ns/1ps
module test_pghist_ctrl;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [1:0]  req_path;
  logic        req_direct_store;
  logic        req_itrans_en;
  logic        req_dtrans_en;
  logic        req_tlb_hit;
  logic        req_tlb_r;
  logic        req_tlb_c;
  logic [31:0] req_pte_addr;
  logic        busy_o;
  logic        bus_rd_req;
  logic [31:0] bus_rd_addr;
  logic        bus_rd_ack;
  logic [7:0]  bus_rd_data;
  logic        bus_wr_req;
  logic [31:0] bus_wr_addr;
  logic [7:0]  bus_wr_data;
  logic        bus_wr_ack;
  logic        done_o;
  logic        noop_o;
  logic        illegal_o;
  logic        tlb_set_c_o;

  int unsigned n_vec = 0;
  int unsigned n_err = 0;

  pghist_ctrl i_pghist_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_kind         (req_kind),
    .req_path         (req_path),
    .req_direct_store (req_direct_store),
    .req_itrans_en    (req_itrans_en),
    .req_dtrans_en    (req_dtrans_en),
    .req_tlb_hit      (req_tlb_hit),
    .req_tlb_r        (req_tlb_r),
    .req_tlb_c        (req_tlb_c),
    .req_pte_addr     (req_pte_addr),
    .busy_o           (busy_o),
    .bus_rd_req       (bus_rd_req),
    .bus_rd_addr      (bus_rd_addr),
    .bus_rd_ack       (bus_rd_ack),
    .bus_rd_data      (bus_rd_data),
    .bus_wr_req       (bus_wr_req),
    .bus_wr_addr      (bus_wr_addr),
    .bus_wr_data      (bus_wr_data),
    .bus_wr_ack       (bus_wr_ack),
    .done_o           (done_o),
    .noop_o           (noop_o),
    .illegal_o        (illegal_o),
    .tlb_set_c_o      (tlb_set_c_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // 0 skip, 1 noop, 2 update, 3 illegal
  function automatic int unsigned exp_act(input logic [1:0] k, input logic [1:0] p,
                                          input logic ds, input logic ie, input logic de,
                                          input logic hit, input logic r, input logic c);
    if (p != 2'd0 || ds || !(ie || de)) return 0;
    if (!hit) return (k >= 2'd2) ? 1 : 2;
    if (!r) return 3;
    if (k == 2'd1 && !c) return 2;
    return 0;
  endfunction

  function automatic string exp_tag(input logic [1:0] k, input logic [1:0] p,
                                    input logic ds, input logic ie, input logic de,
                                    input logic hit, input logic r, input logic c);
    if (p != 2'd0 || ds) return "R1";
    if (!(ie || de)) return "R2";
    if (!hit) return (k >= 2'd2) ? "R6" : "R7";
    if (!r) return "R5";
    if (k == 2'd1 && !c) return "R4";
    return "R3";
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic run_vec(input logic [1:0] k, input logic [1:0] p, input logic ds,
                         input logic ie, input logic de, input logic hit,
                         input logic r, input logic c, input logic [31:0] pte,
                         input logic [7:0] old, input logic poke);
    int unsigned act;
    string       tag;
    logic [7:0]  m;
    logic        exp_wr;
    int          nrd;
    int          nwr;
    int          rd_wait;
    int          wr_wait;
    logic        got;
    logic        s_noop;
    logic        s_ill;
    logic        s_tc;
    logic [31:0] rd_a;
    logic [31:0] wr_a;
    logic [7:0]  wr_d;
    int          extra;
    act    = exp_act(k, p, ds, ie, de, hit, r, c);
    tag    = exp_tag(k, p, ds, ie, de, hit, r, c);
    m      = 8'h02 | ((k == 2'd1) ? 8'h01 : 8'h00);
    exp_wr = (act == 2) && ((old | m) != old);
    nrd = 0; nwr = 0; rd_wait = 0; wr_wait = 0; got = 1'b0;
    s_noop = 1'b0; s_ill = 1'b0; s_tc = 1'b0;
    rd_a = '0; wr_a = '0; wr_d = '0;

    @(negedge clk);
    req_kind = k; req_path = p; req_direct_store = ds;
    req_itrans_en = ie; req_dtrans_en = de;
    req_tlb_hit = hit; req_tlb_r = r; req_tlb_c = c;
    req_pte_addr = pte; req_valid = 1'b1;
    @(negedge clk);
    chk("R9", "busy after accept", {31'd0, busy_o}, 32'd1);
    if (poke) begin
      // store miss held on the inputs while busy: must be ignored
      req_kind = 2'd1; req_path = 2'd0; req_direct_store = 1'b0;
      req_itrans_en = 1'b1; req_dtrans_en = 1'b1; req_tlb_hit = 1'b0;
      req_valid = 1'b1;
    end else begin
      req_valid = 1'b0;
    end
    for (int cyc = 0; cyc < 40; cyc++) begin
      if (cyc > 0) @(negedge clk);
      bus_rd_ack = 1'b0;
      bus_wr_ack = 1'b0;
      if (done_o) begin
        got = 1'b1; s_noop = noop_o; s_ill = illegal_o; s_tc = tlb_set_c_o;
        req_valid = 1'b0;
        break;
      end
      if (bus_rd_req) begin
        nrd++; rd_a = bus_rd_addr; rd_wait = 2 + int'($urandom % 3);
      end
      if (bus_wr_req) begin
        nwr++; wr_a = bus_wr_addr; wr_d = bus_wr_data; wr_wait = 2 + int'($urandom % 3);
      end
      if (rd_wait > 0) begin
        rd_wait--;
        if (rd_wait == 0) begin
          bus_rd_ack = 1'b1; bus_rd_data = old;
        end
      end
      if (wr_wait > 0) begin
        wr_wait--;
        if (wr_wait == 0) bus_wr_ack = 1'b1;
      end
    end
    req_valid = 1'b0;
    chk("R9", "done seen", {31'd0, got}, 32'd1);
    chk(tag, "read count", nrd, (act == 2) ? 1 : 0);
    if (act == 2) chk("R7", "read address", rd_a, pte + 32'd6);
    chk(tag, "write count", nwr, exp_wr ? 1 : 0);
    if (exp_wr) begin
      chk(tag, "write data", {24'd0, wr_d}, {24'd0, old | m});
      chk("R7", "write address", wr_a, pte + 32'd6);
    end
    chk("R6", "noop flag", {31'd0, s_noop}, (act == 1) ? 32'd1 : 32'd0);
    chk("R5", "illegal flag", {31'd0, s_ill}, (act == 3) ? 32'd1 : 32'd0);
    chk("R8", "tlb set C", {31'd0, s_tc}, (act == 2 && k == 2'd1) ? 32'd1 : 32'd0);
    extra = 0;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      if (busy_o || bus_rd_req || bus_wr_req || done_o) extra++;
    end
    chk("R9", "quiet after done", extra, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    int unsigned sink;
    sink = $urandom(32'd4242);
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_path = '0;
    req_direct_store = 1'b0; req_itrans_en = 1'b0; req_dtrans_en = 1'b0;
    req_tlb_hit = 1'b0; req_tlb_r = 1'b0; req_tlb_c = 1'b0; req_pte_addr = '0;
    bus_rd_ack = 1'b0; bus_rd_data = '0; bus_wr_ack = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10", "busy in reset", {31'd0, busy_o}, 32'd0);
    chk("R10", "strobes in reset", {30'd0, bus_rd_req, bus_wr_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", "idle after reset", {29'd0, busy_o, done_o, bus_rd_req}, 32'd0);

    // directed corner cases
    run_vec(2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1000, 8'h00, 1'b0); // R1 block
    run_vec(2'd1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1000, 8'h00, 1'b0); // R1 direct-store
    run_vec(2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1000, 8'h00, 1'b0); // R1 untranslated
    run_vec(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1000, 8'h00, 1'b0); // R2
    run_vec(2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h2000, 8'h00, 1'b0); // R3 load hit
    run_vec(2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h2000, 8'h00, 1'b0); // R3 store hit C=1
    run_vec(2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h2000, 8'h00, 1'b0); // R3 touch hit
    run_vec(2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h3000, 8'hA2, 1'b0); // R4
    run_vec(2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h3000, 8'h00, 1'b0); // R5 rc=00
    run_vec(2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h3000, 8'h00, 1'b0); // R5 rc=01
    run_vec(2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h4000, 8'h00, 1'b0); // R6 touch
    run_vec(2'd3, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h4000, 8'h00, 1'b0); // R6 touch-st
    run_vec(2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h5000, 8'hF4, 1'b0); // R7 load miss
    run_vec(2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h5000, 8'h5B, 1'b0); // R7 bits set: skip write
    run_vec(2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h5000, 8'h02, 1'b0); // R7 R set: skip write
    run_vec(2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h6000, 8'h80, 1'b1); // R9 poke while busy

    // constrained random
    for (int v = 0; v < 150; v++) begin
      logic [1:0] k;
      logic [1:0] p;
      k = 2'($urandom % 4);
      p = (($urandom % 10) < 7) ? 2'd0 : 2'(1 + $urandom % 3);
      run_vec(k, p, (($urandom % 8) == 0), 1'($urandom % 2), (($urandom % 4) != 0),
              1'($urandom % 2), (($urandom % 8) != 0), 1'($urandom % 2),
              $urandom, 8'($urandom % 256), (($urandom % 4) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule